// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external byte-wide asynchronous static RAM with 2^17 locations. The host hands over one request per handshake: a read or write flag, an address and, for writes, a data byte. The block turns that request into a sequence of registered strobes: an active-low select and an active-high select, an active-low output enable and an active-low write enable. Each strobe is held for the number of clock cycles that the memory's nanosecond limits require.

Every timing limit is a nanosecond parameter. It is converted at elaboration into a cycle count: the value is divided by the clock period, rounded up, and never less than one cycle. Reads hold the selects and the output enable until the access time has run out. The returned byte is then captured and handed back with a one-cycle valid pulse. Writes keep output enable high, open a write-enable pulse one cycle after the selects become active, and drive the data bus only while that pulse is low. A build option keeps output enable low across a write. In that mode the pulse is lengthened to cover the memory's output turn-off time plus data setup, and the bus drivers wait for that turn-off before they switch on.

The memory data bus is split into an output, an output enable and an input, so that a tristate pad outside the block can join them.

Top module: `sram_ctrl`

## Requirements
- R1: In reset and until the first request, the active-low select is 1, the active-high select is 0, write and output enables are 1, the data drivers are off, ready is 1 and read-data-valid is 0.
- R2: A request is taken on a clock edge where valid and ready are both 1. Ready then stays 0 for max(N_RC, N_ACC)+1 cycles after a read, or max(N_WC, W+2)+1 cycles after a write. N_x is ceil(T_x / clock period), with a minimum of 1. Valid, flag, address or data presented while ready is 0 have no effect.
- R3: A read drives both selects active and output enable low on the acceptance edge, and holds them for N_ACC = max(N_AA, N_OE) cycles. The address output equals the request address for that whole time.
- R4: A read captures the memory input byte on the edge that ends the N_ACC window. It presents that byte on the read-data output with read-data-valid high for exactly one cycle.
- R5: A write brings write enable low one cycle after the selects go active and holds it low for W = max(N_WP, D+N_DW, N_AW-1) cycles. D is 1 in the default mode. Write enable is only ever low while the memory is selected.
- R6: Data drivers switch on D cycles after write enable falls and switch off one cycle after it rises. While on, they carry the request byte.
- R7: In the default mode output enable stays high throughout a write. The block never drives the bus while output enable is low and write enable is high.
- R8: While the memory is selected, address and selects do not change. Selects and address stay valid for at least N_AW cycles up to the end of write, and data is stable for at least N_DW cycles before it.
- R9: The selects are released one cycle after write enable returns high.
- R10: With the low-output-enable write option, output enable stays low while write enable is low, D = N_WHZ, and W is at least N_WHZ+N_DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Block can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Request address |
| req_wdata_i | input | 8 | Write byte |
| rsp_rdata_o | output | 8 | Captured read byte |
| rsp_valid_o | output | 1 | One-cycle read completion pulse |
| mem_addr_o | output | 17 | Memory address |
| mem_sel_n_o | output | 1 | Active-low memory select |
| mem_sel_o | output | 1 | Active-high memory select |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data pad |
| mem_dq_i | input | 8 | Data from memory |

## Verification
Two things land on the same clock edge at the end of a read: the byte is captured, and output enable and the selects are released. The memory model in the bench puts the stored byte on the bus only once the selected, output-enabled run has reached N_ACC cycles. At every other time it drives a filler value. A capture one edge early therefore returns the filler, and the bench compares the returned byte with the value written earlier. The same model times every write pulse, data window and address window, and reports a fault whenever the bus has two drivers.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WREL,
    ST_RECOV
  } ctl_st_e;

  // ns -> cycles, rounded up, never below one
  function automatic int unsigned to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= mem_dq_i;
  end
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW        = 5,
  parameter int unsigned EL_CAP    = 17,
  parameter int unsigned EL_DRV    = 1,
  parameter int unsigned EL_WEND   = 14,
  parameter int unsigned EL_RR     = 18,
  parameter int unsigned EL_RW     = 18,
  parameter bit          OE_LOW_WR = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [CW-1:0] el_i,
  output logic          fire_o,
  output logic          cap_o,
  output logic          ready_o,
  output logic          rvalid_o,
  output logic          sel_o,
  output logic          oe_o,
  output logic          we_o,
  output logic          drv_o
);
  localparam logic [CW-1:0] C_CAP  = CW'(EL_CAP);
  localparam logic [CW-1:0] C_DRV  = CW'(EL_DRV);
  localparam logic [CW-1:0] C_WEND = CW'(EL_WEND);
  localparam logic [CW-1:0] C_RR   = CW'(EL_RR);
  localparam logic [CW-1:0] C_RW   = CW'(EL_RW);

  ctl_st_e st_q;
  logic    op_wr_q;

  assign fire_o = req_valid_i && ready_o;
  assign cap_o  = (st_q == ST_RD) && (el_i == C_CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_wr_q  <= 1'b0;
      ready_o  <= 1'b1;
      rvalid_o <= 1'b0;
      sel_o    <= 1'b0;
      oe_o     <= 1'b0;
      we_o     <= 1'b0;
      drv_o    <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (fire_o) begin
          ready_o <= 1'b0;
          sel_o   <= 1'b1;
          op_wr_q <= req_write_i;
          oe_o    <= !req_write_i || OE_LOW_WR;
          st_q    <= req_write_i ? ST_WSET : ST_RD;
        end
        ST_RD: if (cap_o) begin
          rvalid_o <= 1'b1;
          sel_o    <= 1'b0;
          oe_o     <= 1'b0;
          st_q     <= ST_RECOV;
        end
        ST_WSET: begin
          we_o <= 1'b1;
          st_q <= ST_WPUL;
        end
        ST_WPUL: begin
          if (el_i == C_DRV) drv_o <= 1'b1;
          if (el_i == C_WEND) begin
            we_o <= 1'b0;
            oe_o <= 1'b0;   // end of write also ends any low OE
            st_q <= ST_WREL;
          end
        end
        ST_WREL: begin
          sel_o <= 1'b0;
          drv_o <= 1'b0;
          st_q  <= ST_RECOV;
        end
        ST_RECOV: if (el_i == (op_wr_q ? C_RW : C_RR)) begin
          ready_o <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned DW        = 8,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned T_RC_NS   = 70,
  parameter int unsigned T_AA_NS   = 70,
  parameter int unsigned T_OE_NS   = 30,
  parameter int unsigned T_WC_NS   = 70,
  parameter int unsigned T_AW_NS   = 60,
  parameter int unsigned T_WP_NS   = 45,
  parameter int unsigned T_DW_NS   = 30,
  parameter int unsigned T_WHZ_NS  = 30,
  parameter bit          OE_LOW_WR = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_sel_n_o,
  output logic          mem_sel_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned N_RC  = to_cyc(T_RC_NS, CLK_PS);
  localparam int unsigned N_AA  = to_cyc(T_AA_NS, CLK_PS);
  localparam int unsigned N_OE  = to_cyc(T_OE_NS, CLK_PS);
  localparam int unsigned N_WC  = to_cyc(T_WC_NS, CLK_PS);
  localparam int unsigned N_AW  = to_cyc(T_AW_NS, CLK_PS);
  localparam int unsigned N_WP  = to_cyc(T_WP_NS, CLK_PS);
  localparam int unsigned N_DW  = to_cyc(T_DW_NS, CLK_PS);
  localparam int unsigned N_WHZ = to_cyc(T_WHZ_NS, CLK_PS);
  localparam int unsigned N_ACC = umax(N_AA, N_OE);
  localparam int unsigned D_DRV = OE_LOW_WR ? N_WHZ : 1;
  localparam int unsigned W_LEN = umax(N_WP, umax(D_DRV + N_DW, N_AW - 1));
  localparam int unsigned R_RD  = umax(N_RC, N_ACC) + 1;
  localparam int unsigned R_WR  = umax(N_WC, W_LEN + 2) + 1;
  localparam int unsigned CW    = $clog2(umax(R_RD, R_WR) + 1);

  logic [CW-1:0] el;
  logic fire, cap, sel, oe, we, drv;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (fire),
    .cnt_o (el)
  );

  sram_ctrl_fsm #(
    .CW       (CW),
    .EL_CAP   (N_ACC - 1),
    .EL_DRV   (D_DRV),
    .EL_WEND  (W_LEN),
    .EL_RR    (R_RD - 1),
    .EL_RW    (R_WR - 1),
    .OE_LOW_WR(OE_LOW_WR)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .el_i       (el),
    .fire_o     (fire),
    .cap_o      (cap),
    .ready_o    (req_ready_o),
    .rvalid_o   (rsp_valid_o),
    .sel_o      (sel),
    .oe_o       (oe),
    .we_o       (we),
    .drv_o      (drv)
  );

  sram_ctrl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fire),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .cap_i   (cap),
    .mem_dq_i(mem_dq_i),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_dq_o),
    .rdata_o (rsp_rdata_o)
  );

  assign mem_sel_n_o = !sel;
  assign mem_sel_o   = sel;
  assign mem_oe_n_o  = !oe;
  assign mem_we_n_o  = !we;
  assign mem_dq_oe_o = drv;
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int unsigned AW        = 17,
  parameter bit          OE_LOW_WR = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_sel_n_o,
  input logic          mem_sel_o,
  input logic          mem_oe_n_o,
  input logic          mem_we_n_o,
  input logic          mem_dq_oe_o
);
  logic sel_w;
  assign sel_w = !mem_sel_n_o && mem_sel_o;

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R2
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R4
  AST_WE_WHILE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> sel_w); // R5
  AST_DRV_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> !mem_we_n_o); // R6
  AST_NO_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_n_o || !mem_we_n_o)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_w && $past(sel_w)) |-> $stable(mem_addr_o)); // R8
  AST_SEL_AFTER_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> sel_w); // R9

  if (OE_LOW_WR) begin : g_oe_low
    AST_OE_LOW_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mem_we_n_o |-> !mem_oe_n_o); // R10
  end else begin : g_oe_high
    AST_OE_HIGH_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mem_we_n_o |-> mem_oe_n_o); // R7
  end
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .OE_LOW_WR(OE_LOW_WR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_addr_o (mem_addr_o),
  .mem_sel_n_o(mem_sel_n_o),
  .mem_sel_o  (mem_sel_o),
  .mem_oe_n_o (mem_oe_n_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + 3999) / 4000;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_ACC = mx(cyc(70), cyc(30));
  localparam int N_WP  = cyc(45);
  localparam int N_DW  = cyc(30);
  localparam int N_AW  = cyc(60);
  localparam int N_WHZ = cyc(30);
  localparam int W0    = mx(N_WP, mx(1 + N_DW, N_AW - 1));
  localparam int W1    = mx(N_WP, mx(N_WHZ + N_DW, N_AW - 1));
  localparam int R_RD  = mx(cyc(70), N_ACC) + 1;
  localparam int R_W0  = mx(cyc(70), W0 + 2) + 1;
  localparam int R_W1  = mx(cyc(70), W1 + 2) + 1;

  // {write, addr, byte}: byte is write data or expected read data
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'hA5}, {1'b1, 17'h1FFFF, 8'h5A}, {1'b1, 17'h0AAAA, 8'h3C},
    {1'b1, 17'h15555, 8'hC3}, {1'b1, 17'h00001, 8'hFF}, {1'b0, 17'h00000, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h5A}, {1'b0, 17'h0AAAA, 8'h3C}, {1'b0, 17'h15555, 8'hC3},
    {1'b0, 17'h00001, 8'hFF}, {1'b1, 17'h00000, 8'h00}, {1'b0, 17'h00000, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = !clk;

  logic        req_valid = 1'b0, req_write = 1'b0, ready, rvalid;
  logic [16:0] req_addr = '0, m_addr;
  logic [7:0]  req_wdata = '0, rdata, m_dq_o, m_dq_i;
  logic        m_sel_n, m_sel, m_oe_n, m_we_n, m_dq_oe;

  sram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rdata), .rsp_valid_o(rvalid), .mem_addr_o(m_addr),
    .mem_sel_n_o(m_sel_n), .mem_sel_o(m_sel), .mem_oe_n_o(m_oe_n), .mem_we_n_o(m_we_n),
    .mem_dq_o(m_dq_o), .mem_dq_oe_o(m_dq_oe), .mem_dq_i(m_dq_i)
  );

  logic        v1 = 1'b0, rdy1, rv1, s1_n, s1, oe1_n, we1_n, dqoe1;
  logic [16:0] a1;
  logic [7:0]  rd1, dq1;
  sram_ctrl #(.OE_LOW_WR(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v1), .req_ready_o(rdy1),
    .req_write_i(1'b1), .req_addr_i(17'h00123), .req_wdata_i(8'h7E),
    .rsp_rdata_o(rd1), .rsp_valid_o(rv1), .mem_addr_o(a1),
    .mem_sel_n_o(s1_n), .mem_sel_o(s1), .mem_oe_n_o(oe1_n), .mem_we_n_o(we1_n),
    .mem_dq_o(dq1), .mem_dq_oe_o(dqoe1), .mem_dq_i(8'h00)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // cycle-based memory model, evaluated away from the active edge
  logic [7:0] mem [int];
  int sel_run = 0, rd_run = 0, wl = 0, dstab = 0, wr_sel = 0;
  logic prev_sel = 1'b0, prev_we_n = 1'b1;
  logic [16:0] prev_addr = '0;
  logic [7:0]  last_dq = '0;
  initial m_dq_i = 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic sel = !m_sel_n && m_sel;
      sel_run = sel ? ((prev_sel && m_addr == prev_addr) ? sel_run + 1 : 1) : 0;
      rd_run  = (sel && !m_oe_n && m_we_n) ? rd_run + 1 : 0;
      if (rd_run >= N_ACC)
        m_dq_i = mem.exists(int'(m_addr)) ? mem[int'(m_addr)] : 8'h00;
      else
        m_dq_i = 8'hEE;
      if (m_dq_oe && sel && !m_oe_n && m_we_n)
        chk(1'b0, "R7 bus has two drivers", 1, 0);
      if (sel && !m_we_n) begin
        if (prev_sel && !prev_we_n && m_addr != prev_addr)
          chk(1'b0, "R8 address moved during write", int'(m_addr), int'(prev_addr));
        wl++;
        wr_sel = sel_run;
        if (m_dq_oe) begin
          dstab = (dstab > 0 && m_dq_o == last_dq) ? dstab + 1 : 1;
          last_dq = m_dq_o;
        end else dstab = 0;
      end
      if (!prev_we_n && m_we_n) begin
        chk(wl >= N_WP, "R5 model pulse width", wl, N_WP);
        chk(dstab >= N_DW, "R8 model data setup", dstab, N_DW);
        chk(wr_sel >= N_AW, "R8 model address window", wr_sel, N_AW);
        mem[int'(prev_addr)] = last_dq;
        wl = 0;
        dstab = 0;
      end
      prev_sel  = sel;
      prev_we_n = m_we_n;
      prev_addr = m_addr;
    end
  end

  task automatic do_op(input logic wr, input logic [16:0] a, input logic [7:0] d, input bit hold);
    int k = 0, rv_at = 0, we_first = 0, we_last = 0, we_cnt = 0;
    int dq_first = 0, dq_last = 0, sel_last = 0, oe_low = 0;
    bit addr_bad = 0, dq_bad = 0, done = 0;
    logic [7:0] cap = '0;
    @(negedge clk);
    chk(ready === 1'b1, "R2 ready before request", int'(ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!done) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        if (hold) begin req_write = !wr; req_addr = a ^ 17'h10; req_wdata = ~d; end
        else req_valid = 1'b0;
      end
      if (k == 4) req_valid = 1'b0;
      if (rvalid) begin rv_at = k; cap = rdata; end
      if (!m_we_n) begin if (we_first == 0) we_first = k; we_last = k; we_cnt++; end
      if (m_dq_oe) begin
        if (dq_first == 0) dq_first = k;
        dq_last = k;
        if (m_dq_o != d) dq_bad = 1;
      end
      if (!m_oe_n) oe_low++;
      if (!m_sel_n && m_sel) begin sel_last = k; if (m_addr != a) addr_bad = 1; end
      if (ready || k > 100) done = 1;
    end
    chk(!addr_bad, "R3 address held at request value", 0, 0);
    if (!wr) begin
      chk(k == R_RD + 1, "R2 read busy length", k, R_RD + 1);
      chk(sel_last == N_ACC, "R3 read select span", sel_last, N_ACC);
      chk(oe_low == N_ACC, "R3 read OE span", oe_low, N_ACC);
      chk(rv_at == N_ACC + 1, "R4 valid pulse cycle", rv_at, N_ACC + 1);
      chk(cap == d, "R4 read byte", int'(cap), int'(d));
      chk(we_cnt == 0 && dq_first == 0, "R7 no write activity on read", we_cnt, 0);
    end else begin
      chk(k == R_W0 + 1, "R2 write busy length", k, R_W0 + 1);
      chk(we_first == 2 && we_cnt == W0, "R5 write pulse length", we_cnt, W0);
      chk(dq_first == we_first + 1 && dq_last == we_last + 1, "R6 driver window", dq_first, we_first + 1);
      chk(!dq_bad, "R6 driven byte", int'(m_dq_o), int'(d));
      chk(oe_low == 0, "R7 OE high in write", oe_low, 0);
      chk(sel_last == we_last + 1, "R9 select release", sel_last, we_last + 1);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({m_sel_n, m_sel, m_oe_n, m_we_n, m_dq_oe, ready, rvalid} == 7'b1011010,
        "R1 outputs in reset", {m_sel_n, m_sel, m_oe_n, m_we_n, m_dq_oe, ready, rvalid}, 7'b1011010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({m_sel_n, m_sel, m_oe_n, m_we_n, m_dq_oe, ready, rvalid} == 7'b1011010,
        "R1 outputs after reset", {m_sel_n, m_sel, m_oe_n, m_we_n, m_dq_oe, ready, rvalid}, 7'b1011010);

    for (int i = 0; i < NV; i++)
      do_op(VEC[i][25], VEC[i][24:8], VEC[i][7:0], 1'b0);

    // R2: inputs changed and valid held while busy are ignored
    do_op(1'b1, 17'h0BEEF, 8'h69, 1'b1);
    do_op(1'b0, 17'h0BEEF, 8'h69, 1'b1);
    do_op(1'b0, 17'h0BEEF, 8'h69, 1'b0);

    // R10: write with OE held low on the variant instance
    begin
      int k = 0, we_first = 0, we_cnt = 0, dq_first = 0;
      bit oe_bad = 0, byte_bad = 0, done = 0;
      @(negedge clk);
      v1 = 1'b1;
      while (!done) begin
        @(negedge clk);
        k++;
        if (k == 1) v1 = 1'b0;
        if (!we1_n) begin
          if (we_first == 0) we_first = k;
          we_cnt++;
          if (oe1_n) oe_bad = 1;
        end
        if (dqoe1) begin
          if (dq_first == 0) dq_first = k;
          if (dq1 != 8'h7E) byte_bad = 1;
        end
        if (rdy1 || k > 100) done = 1;
      end
      chk(we_cnt == W1, "R10 stretched pulse", we_cnt, W1);
      chk(we_cnt >= N_WHZ + N_DW, "R10 turn-off plus setup", we_cnt, N_WHZ + N_DW);
      chk(!oe_bad, "R10 OE low through write", 1, 0);
      chk(dq_first == we_first + N_WHZ, "R10 driver delay", dq_first, we_first + N_WHZ);
      chk(!byte_bad, "R10 driven byte", int'(dq1), 8'h7E);
      chk(k == R_W1 + 1, "R10 busy length", k, R_W1 + 1);
    end

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule